// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time as a set of binary calendar fields: seconds, minutes, hours, day of week, day of month, month, and a year offset from 0 to 99. A one-cycle pulse on `tick` arrives once per second and advances the calendar. Day-of-month rollover follows the length of the current month and the leap-year rule. A second bank of fields holds an alarm time. A match mask selects which fields take part in the compare. When the compare succeeds on a tick, the block sets a sticky pending flag and raises an interrupt.

Software uses a single-cycle register port: a write strobe with address and data, and read data that follows the address combinationally. After reset the calendar is locked. It does not count, and it ignores writes to the time and alarm fields, until a fixed series of seven key writes has landed in order. To set the clock, software sets the halt bit, writes the fields, and clears the halt bit again. A 3-bit debounce setting is stored for use by neighbouring logic.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the time reads year 0, month 1, day 1, weekday 0, 00:00:00, and `irq` is low. Until the unlock series completes, ticks do not advance the time, and writes to the time fields (0x40-0x58) and alarm fields (0x60-0x78) are ignored.
- R2: The unlock series is seven full-word writes, in this order: 0xc6 to 0x04, 0x9a to 0x08, 0x59 to 0x0c, 0xa3 to 0x10, 0x57 to 0x14, 0x67 to 0x18, 0xd2 to 0x1c. Any other write inside 0x04-0x1c restarts the series; a write of the first key counts as step one. Once complete, the block stays unlocked until reset.
- R3: Bit 0 of 0x20 is the halt bit. While it is set, ticks do not advance the time. A time field accepts a write only while the block is unlocked and halted.
- R4: Each field sits at a word address: year 0x40, month 0x44, day of month 0x48, weekday 0x4c, hour 0x50, minute 0x54, second 0x58. On a tick, seconds step from 59 to 0 and carry into minutes, minutes step from 59 to 0 and carry into hours, and hours step from 23 to 0 and carry into the day.
- R5: At the day carry, the day of month returns to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is nonzero and divisible by 4, and 28 days otherwise (year 0 included). All other months have 31 days.
- R6: At the month carry, month 12 becomes 1 and the year increments, with year 99 wrapping to 0.
- R7: At each day carry, the weekday steps by one, and 6 wraps to 0.
- R8: Alarm fields sit at the time address plus 0x20. The alarm control byte at 0x7c has these bits: 0 enable, 1 second, 2 minute, 3 hour, 4 weekday, 5 day, 6 month, 7 year. On a counting tick with the enable bit set, the pending flag (bit 4 of 0x30) sets if every selected alarm field equals the value the time takes on that tick.
- R9: The pending flag stays set until a write to 0x30 with bit 4 set. Writing 0 there has no effect.
- R10: `irq` is high exactly when the pending flag and enable bit 0 of 0x7c are both set. Writing 0 to 0x7c drops `irq` without clearing the pending flag.
- R11: 0x2c holds a 3-bit debounce value in bits 2:0. The upper bits read as 0.
- R12: All calendar fields take their new values on the same clock edge, the one on which the tick is sampled. A read made after that edge sees a consistent time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that `tick` lasts one cycle and never coincides with a write to a time field. Such a write happens only while the block is halted, and a halted block does not count. The single-step seconds property also assumes the seconds field holds a legal value below 59. The bench loads every time field through the register port with in-range values and raises `tick` only between register accesses, so the assertions' assumptions hold throughout.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int ADDR_W    = 8;
    localparam int NUM_KEYS  = 7;
    localparam int KEY_BASE  = 'h04;
    localparam int KEY_LAST  = KEY_BASE + 4 * (NUM_KEYS - 1);
    localparam int CTL_ADDR  = 'h20;
    localparam int DBNC_ADDR = 'h2c;
    localparam int STAT_ADDR = 'h30;
    localparam int PEND_BIT  = 4;
    localparam int DBNC_W    = 3;
    localparam int NUM_FLD   = 7;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] dom;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{year: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd0,
                                   hour: 5'd0, min: 6'd0, sec: 6'd0};

    function automatic logic [7:0] key_val(logic [2:0] s);
        case (s)
            3'd0:    return 8'hc6;
            3'd1:    return 8'h9a;
            3'd2:    return 8'h59;
            3'd3:    return 8'ha3;
            3'd4:    return 8'h57;
            3'd5:    return 8'h67;
            3'd6:    return 8'hd2;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] key_addr(logic [2:0] s);
        return ADDR_W'(KEY_BASE + 4 * int'(s));
    endfunction

    function automatic logic [4:0] month_len(logic [3:0] mon, logic [6:0] yr);
        case (mon)
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            4'd2:    return (yr != 7'd0 && yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            default: return 5'd31;
        endcase
    endfunction

    // field index follows word order: year, month, day, weekday, hour, minute, second
    function automatic logic [7:0] get_field(cal_t c, logic [2:0] idx);
        case (idx)
            3'd0:    return {1'b0, c.year};
            3'd1:    return {4'b0, c.mon};
            3'd2:    return {3'b0, c.dom};
            3'd3:    return {5'b0, c.dow};
            3'd4:    return {3'b0, c.hour};
            3'd5:    return {2'b0, c.min};
            3'd6:    return {2'b0, c.sec};
            default: return 8'h00;
        endcase
    endfunction

    function automatic cal_t set_field(cal_t c, logic [2:0] idx, logic [7:0] v);
        cal_t r = c;
        case (idx)
            3'd0:    r.year = v[6:0];
            3'd1:    r.mon  = v[3:0];
            3'd2:    r.dom  = v[4:0];
            3'd3:    r.dow  = v[2:0];
            3'd4:    r.hour = v[4:0];
            3'd5:    r.min  = v[5:0];
            3'd6:    r.sec  = v[5:0];
            default: r = c;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rtc_unlock.sv
module rtc_unlock
    import rtc_cal_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              open
);
    typedef struct packed {
        logic [2:0] step;
        logic       open;
    } ulk_t;

    ulk_t q, d;
    logic in_win;

    always_comb begin
        d      = q;
        in_win = (int'(addr) >= KEY_BASE) && (int'(addr) <= KEY_LAST) && (addr[1:0] == 2'b00);
        if (wr_en && !q.open && in_win) begin
            if (addr == key_addr(q.step) && wr_data == DATA_W'(key_val(q.step))) begin
                if (q.step == 3'(NUM_KEYS - 1)) begin
                    d.open = 1'b1;
                    d.step = 3'd0;
                end else begin
                    d.step = q.step + 3'd1;
                end
            end else if (addr == key_addr(3'd0) && wr_data == DATA_W'(key_val(3'd0))) begin
                d.step = 3'd1;
            end else begin
                d.step = 3'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign open = q.open;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       ld_en,
    input  logic [2:0] ld_idx,
    input  logic [7:0] ld_val,
    output cal_t       cal_q,
    output cal_t       cal_d
);
    always_comb begin
        cal_d = cal_q;
        if (adv) begin
            if (cal_q.sec >= 6'd59) begin
                cal_d.sec = 6'd0;
                if (cal_q.min >= 6'd59) begin
                    cal_d.min = 6'd0;
                    if (cal_q.hour >= 5'd23) begin
                        cal_d.hour = 5'd0;
                        cal_d.dow  = (cal_q.dow >= 3'd6) ? 3'd0 : cal_q.dow + 3'd1;
                        if (cal_q.dom >= month_len(cal_q.mon, cal_q.year)) begin
                            cal_d.dom = 5'd1;
                            if (cal_q.mon >= 4'd12) begin
                                cal_d.mon  = 4'd1;
                                cal_d.year = (cal_q.year >= 7'd99) ? 7'd0 : cal_q.year + 7'd1;
                            end else begin
                                cal_d.mon = cal_q.mon + 4'd1;
                            end
                        end else begin
                            cal_d.dom = cal_q.dom + 5'd1;
                        end
                    end else begin
                        cal_d.hour = cal_q.hour + 5'd1;
                    end
                end else begin
                    cal_d.min = cal_q.min + 6'd1;
                end
            end else begin
                cal_d.sec = cal_q.sec + 6'd1;
            end
        end else if (ld_en) begin
            cal_d = set_field(cal_q, ld_idx, ld_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= CAL_RESET;
        else        cal_q <= cal_d;
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fld_wr,
    input  logic       ctl_wr,
    input  logic [2:0] idx,
    input  logic [7:0] wval,
    input  logic       clr,
    input  logic       adv,
    input  cal_t       cal_nxt,
    output cal_t       alm_q,
    output logic [7:0] ctl_q,
    output logic       pend_q,
    output logic       irq
);
    typedef struct packed {
        cal_t       alm;
        logic [7:0] ctl;
        logic       pend;
    } alm_st_t;

    alm_st_t q, d;
    logic    hit;

    always_comb begin
        d   = q;
        hit = q.ctl[0];
        // mask bit i selects field index NUM_FLD-i (bit 1 second ... bit 7 year)
        for (int i = 1; i <= NUM_FLD; i++) begin
            if (q.ctl[i] && get_field(q.alm, 3'(NUM_FLD - i)) != get_field(cal_nxt, 3'(NUM_FLD - i)))
                hit = 1'b0;
        end
        if (fld_wr) d.alm = set_field(q.alm, idx, wval);
        if (ctl_wr) d.ctl = wval;
        if (clr)    d.pend = 1'b0;
        if (adv && hit) d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{alm: CAL_RESET, ctl: 8'h00, pend: 1'b0};
        else        q <= d;
    end

    assign alm_q  = q.alm;
    assign ctl_q  = q.ctl;
    assign pend_q = q.pend;
    assign irq    = q.pend & q.ctl[0];
endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
    import rtc_cal_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam logic [2:0] TIME_BANK = 3'b010;
    localparam logic [2:0] ALM_BANK  = 3'b011;

    typedef struct packed {
        logic              halt;
        logic [DBNC_W-1:0] dbnc;
    } top_t;

    top_t       q, d;
    logic       open, adv, aligned, tm_ld, al_wr, actl_wr, clr;
    logic [2:0] idx;
    cal_t       cal_q, cal_d, alm_q;
    logic [7:0] alm_ctl;
    logic       pend;

    assign idx     = addr[4:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign adv     = tick && open && !q.halt;
    assign tm_ld   = wr_en && open && q.halt && aligned && addr[7:5] == TIME_BANK && idx != 3'd7;
    assign al_wr   = wr_en && open && aligned && addr[7:5] == ALM_BANK && idx != 3'd7;
    assign actl_wr = wr_en && aligned && addr[7:5] == ALM_BANK && idx == 3'd7;
    assign clr     = wr_en && addr == ADDR_W'(STAT_ADDR) && wr_data[PEND_BIT];

    always_comb begin
        d = q;
        if (wr_en && addr == ADDR_W'(CTL_ADDR))  d.halt = wr_data[0];
        if (wr_en && addr == ADDR_W'(DBNC_ADDR)) d.dbnc = wr_data[DBNC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    rtc_unlock #(.DATA_W(DATA_W)) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .open(open)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .adv(adv), .ld_en(tm_ld), .ld_idx(idx),
        .ld_val(wr_data[7:0]), .cal_q(cal_q), .cal_d(cal_d)
    );

    rtc_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .fld_wr(al_wr), .ctl_wr(actl_wr), .idx(idx),
        .wval(wr_data[7:0]), .clr(clr), .adv(adv), .cal_nxt(cal_d),
        .alm_q(alm_q), .ctl_q(alm_ctl), .pend_q(pend), .irq(irq)
    );

    always_comb begin
        rd_data = '0;
        if (aligned) begin
            case (addr[7:5])
                TIME_BANK: if (idx != 3'd7) rd_data = DATA_W'(get_field(cal_q, idx));
                ALM_BANK:  rd_data = (idx == 3'd7) ? DATA_W'(alm_ctl) : DATA_W'(get_field(alm_q, idx));
                default: begin
                    if (addr == ADDR_W'(CTL_ADDR))  rd_data = DATA_W'(q.halt);
                    if (addr == ADDR_W'(DBNC_ADDR)) rd_data = DATA_W'(q.dbnc);
                    if (addr == ADDR_W'(STAT_ADDR)) rd_data = DATA_W'({pend, 4'b0000});
                end
            endcase
        end
    end
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              open,
    input logic              halt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wr_data,
    input cal_t              cal,
    input logic              pend,
    input logic              irq
);
    // R1
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(cal));

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open && halt && !wr_en) |=> $stable(cal));

    // R4
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open && !halt && tick && !wr_en && cal.sec < 6'd59) |=> cal.sec == $past(cal.sec) + 6'd1);

    // R6
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open && !halt && tick && cal.year == 7'd99 && cal.mon == 4'd12 && cal.dom == 5'd31 &&
         cal.hour == 5'd23 && cal.min == 6'd59 && cal.sec == 6'd59) |=> cal.year == 7'd0 && cal.mon == 4'd1);

    // R9
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(wr_en && addr == ADDR_W'(STAT_ADDR) && wr_data[PEND_BIT])) |=> pend);

    // R10
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend);

    // R10
    alarm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h7c && !wr_data[0]) |=> !irq);
endmodule

bind rtc_cal_top rtc_cal_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .open(open), .halt(q.halt),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .cal(cal_q), .pend(pend), .irq(irq)
);

// File: tb/rtc_cal_top_tb.sv
`timescale 1ns/1ps
module rtc_cal_top_tb;
    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        irq;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rtc_cal_top u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
                       .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; #1; v = rd_data;
    endtask

    task automatic tick1();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic unlock();
        logic [7:0] keys [7] = '{8'hc6, 8'h9a, 8'h59, 8'ha3, 8'h57, 8'h67, 8'hd2};
        for (int i = 0; i < 7; i++) wr(8'(4 + 4 * i), 32'(keys[i]));
    endtask

    function automatic int mdays(int m, int y);
        if (m == 2) return (y != 0 && y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] pk(int y, int m, int d, int w, int h, int mi, int s);
        return {8'h00, 8'(y), 8'(m), 8'(d), 8'(w), 8'(h), 8'(mi), 8'(s)};
    endfunction

    task automatic step_model(inout int y, inout int m, inout int d, inout int w,
                              inout int h, inout int mi, inout int s);
        s++;
        if (s == 60) begin s = 0; mi++; end
        if (mi == 60) begin mi = 0; h++; end
        if (h == 24) begin
            h = 0; w = (w + 1) % 7; d++;
            if (d > mdays(m, y)) begin
                d = 1; m++;
                if (m == 13) begin m = 1; y = (y + 1) % 100; end
            end
        end
    endtask

    task automatic set_time(int y, int m, int d, int w, int h, int mi, int s);
        wr(8'h20, 32'h1);
        wr(8'h40, 32'(y)); wr(8'h44, 32'(m)); wr(8'h48, 32'(d)); wr(8'h4c, 32'(w));
        wr(8'h50, 32'(h)); wr(8'h54, 32'(mi)); wr(8'h58, 32'(s));
        wr(8'h20, 32'h0);
    endtask

    task automatic set_alarm(int y, int m, int d, int w, int h, int mi, int s);
        wr(8'h60, 32'(y)); wr(8'h64, 32'(m)); wr(8'h68, 32'(d)); wr(8'h6c, 32'(w));
        wr(8'h70, 32'(h)); wr(8'h74, 32'(mi)); wr(8'h78, 32'(s));
    endtask

    task automatic rd_time(output logic [63:0] t);
        logic [31:0] v [7];
        for (int i = 0; i < 7; i++) rd(8'(8'h40 + 4 * i), v[i]);
        t = {8'h00, v[0][7:0], v[1][7:0], v[2][7:0], v[3][7:0], v[4][7:0], v[5][7:0], v[6][7:0]};
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] t;
        int y, m, d, w, h, mi, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_time(t);
        check(t == pk(0, 1, 1, 0, 0, 0, 0), "R1 reset time", t, pk(0, 1, 1, 0, 0, 0, 0));
        check(irq == 1'b0, "R1 reset irq", 64'(irq), 64'd0);
        // R1 locked: no counting, writes ignored
        repeat (3) tick1();
        wr(8'h20, 32'h1); wr(8'h58, 32'd5); wr(8'h78, 32'd9); wr(8'h20, 32'h0);
        rd(8'h58, v); check(v == 0, "R1 locked time", 64'(v), 64'd0);
        rd(8'h78, v); check(v == 0, "R1 locked alarm", 64'(v), 64'd0);

        // R2 broken series stays locked
        wr(8'h04, 32'hc6); wr(8'h08, 32'h9a); wr(8'h0c, 32'h59); wr(8'h10, 32'h00);
        wr(8'h14, 32'h57); wr(8'h18, 32'h67); wr(8'h1c, 32'hd2);
        tick1();
        rd(8'h58, v); check(v == 0, "R2 wrong key keeps lock", 64'(v), 64'd0);
        unlock();
        tick1();
        rd(8'h58, v); check(v == 1, "R2 unlocked counts", 64'(v), 64'd1);

        // R11 debounce width
        wr(8'h2c, 32'hffff_ffff);
        rd(8'h2c, v); check(v == 32'd7, "R11 debounce", 64'(v), 64'd7);
        wr(8'h2c, 32'h2);
        rd(8'h2c, v); check(v == 32'd2, "R11 debounce", 64'(v), 64'd2);

        // R3 halt holds; writes while running ignored
        wr(8'h20, 32'h1);
        rd(8'h20, v); check(v == 1, "R3 halt readback", 64'(v), 64'd1);
        tick1();
        rd(8'h58, v); check(v == 1, "R3 halted no count", 64'(v), 64'd1);
        wr(8'h20, 32'h0);
        wr(8'h58, 32'd40);
        rd(8'h58, v); check(v == 1, "R3 running write ignored", 64'(v), 64'd1);

        // R4 R12 seconds/minutes/hours sweep
        y = 5; m = 3; d = 10; w = 2; h = 0; mi = 0; s = 0;
        set_time(y, m, d, w, h, mi, s);
        for (int k = 0; k < 3700; k++) begin
            tick1();
            step_model(y, m, d, w, h, mi, s);
            rd_time(t);
            check(t == pk(y, m, d, w, h, mi, s), "R4 R12 sweep", t, pk(y, m, d, w, h, mi, s));
        end

        // R5 R6 R7 every month of every year, last day and day before
        for (int yy = 0; yy < 100; yy++) begin
            for (int mm = 1; mm <= 12; mm++) begin
                for (int back = 0; back < 2; back++) begin
                    y = yy; m = mm; d = mdays(mm, yy) - back; w = (yy + mm) % 7;
                    h = 23; mi = 59; s = 59;
                    set_time(y, m, d, w, h, mi, s);
                    tick1();
                    step_model(y, m, d, w, h, mi, s);
                    rd_time(t);
                    check(t == pk(y, m, d, w, h, mi, s), "R5 R6 R7 date carry", t, pk(y, m, d, w, h, mi, s));
                end
            end
        end

        // R8 R10 full-field match
        set_time(20, 6, 15, 1, 10, 20, 30);
        set_alarm(20, 6, 15, 1, 10, 20, 31);
        wr(8'h7c, 32'hff);
        rd(8'h30, v); check(v == 0 && irq == 0, "R8 no early pend", 64'(v), 64'd0);
        tick1();
        rd(8'h30, v); check(v == 32'h10, "R8 pend on match", 64'(v), 64'h10);
        check(irq == 1'b1, "R10 irq raised", 64'(irq), 64'd1);
        // R9 sticky and write-one-to-clear
        tick1();
        rd(8'h30, v); check(v == 32'h10, "R9 sticky", 64'(v), 64'h10);
        wr(8'h30, 32'h0);
        rd(8'h30, v); check(v == 32'h10, "R9 zero write no effect", 64'(v), 64'h10);
        wr(8'h30, 32'h10);
        rd(8'h30, v); check(v == 0, "R9 cleared", 64'(v), 64'd0);
        check(irq == 1'b0, "R10 irq cleared", 64'(irq), 64'd0);
        // R8 mismatch in an enabled field (time now 10:20:32)
        wr(8'h78, 32'd33); wr(8'h74, 32'd21);
        tick1();
        rd(8'h30, v); check(v == 0, "R8 minute mismatch", 64'(v), 64'd0);
        // R8 seconds-only mask
        wr(8'h7c, 32'h03); wr(8'h78, 32'd34);
        tick1();
        rd(8'h30, v); check(v == 32'h10, "R8 masked match", 64'(v), 64'h10);
        // R10 disabling drops irq, flag kept
        wr(8'h7c, 32'h0);
        check(irq == 1'b0, "R10 disable drops irq", 64'(irq), 64'd0);
        rd(8'h30, v); check(v == 32'h10, "R10 pend kept", 64'(v), 64'h10);
        wr(8'h30, 32'h10);
        // R8 enable bit low: no pend even on match
        wr(8'h7c, 32'hfe);
        set_alarm(20, 6, 15, 1, 10, 20, 35);
        tick1();
        rd(8'h30, v); check(v == 0 && irq == 0, "R8 enable off", 64'(v), 64'd0);

        done = 1;
        summary();
    end
endmodule